// File: doc/BRIEF.md
# Phased Gated Clock Divider

This block derives the core clock of a storage-card host controller from one source clock. It does not make new clock nets. It produces three single-cycle clock enables, one each for the core, transmit and receive sides. Each enable fires once per divided period, and each can be moved by a quarter of that period. A 6-bit divide value sets the period length. A value of 0 switches the clock off. A value of 1 bypasses the divider, so every enable is high on every source cycle.

A gate decides, once per period, whether the next divided period runs. The gate closes when the stop bit is set. It also closes when the keep-running bit is clear and there is neither register access nor descriptor execution. With automatic gating enabled, it also closes when the bus is idle and no descriptor is waiting. The divide value, the three phase selects and the two stored delay-line settings are all captured only at a period boundary. A period that starts therefore always runs to the end with one fixed set of settings.

Top module: `clkdiv_phased_gate`

## Requirements
- R1: While the captured divide value is 0, no enable fires and `clk_running_o` is 0. A new value is captured on every source cycle.
- R2: While the captured divide value is 1 and the gate is open, `core_ce_o`, `tx_ce_o` and `rx_ce_o` are high on every source cycle.
- R3: While the captured divide value N is 2 to 63 and the gate is open, `core_ce_o` fires exactly once every N source cycles.
- R4: Number the cycles of one period from position 0, which is the first cycle after the boundary, up to N-1. Each enable fires at position ((p*N+2)/4) mod N, with integer division. The phase select p uses the encoding 0=0°, 1=90°, 2=180°, 3=270°.
- R5: A period boundary is the last cycle of a period, or any cycle while the captured divide value is 0. Changes to the divide or phase inputs take effect only at the next boundary. A period already under way keeps its old length.
- R6: When `stop_i` is 1 at a boundary, the next period is gated, whatever the activity inputs are.
- R7: With `always_on_i`=0, the gate closes at a boundary when both `reg_access_i` and `desc_active_i` are 0. It opens at a boundary when either of them is 1.
- R8: With `auto_gate_i`=1, the gate closes at a boundary when `bus_idle_i`=1 and `desc_pending_i`=0.
- R9: `tx_dly_o` and `rx_dly_o` take the values of `tx_dly_i` and `rx_dly_i` at each boundary, and hold them in between.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_i | input | 6 | Divide value (0 = off, 1 = bypass) |
| core_ph_i | input | 2 | Core quarter-phase select |
| tx_ph_i | input | 2 | Transmit quarter-phase select |
| rx_ph_i | input | 2 | Receive quarter-phase select |
| tx_dly_i | input | 4 | Transmit delay-line step setting |
| rx_dly_i | input | 4 | Receive delay-line step setting |
| always_on_i | input | 1 | Keep the clock running without activity |
| auto_gate_i | input | 1 | Enable idle-bus automatic gating |
| stop_i | input | 1 | Force the clock off |
| reg_access_i | input | 1 | Register access in progress |
| desc_active_i | input | 1 | Descriptor execution in progress |
| bus_idle_i | input | 1 | Card bus is idle |
| desc_pending_i | input | 1 | A descriptor is waiting |
| core_ce_o | output | 1 | Core clock enable |
| tx_ce_o | output | 1 | Transmit clock enable |
| rx_ce_o | output | 1 | Receive clock enable |
| tx_dly_o | output | 4 | Captured transmit delay setting |
| rx_dly_o | output | 4 | Captured receive delay setting |
| clk_running_o | output | 1 | The current divided period is open |

## Verification
A wrong period counter shows up within one divided period. The core enable spacing stops matching the captured divide value. The transmit and receive enables also move away from the positions given by their phase rounding. A wrong capture of the settings or of the gate is seen at the next boundary, which is at most 63 source cycles later. It appears as an enable that fires inside a gated period, as a new divide value that shortens a period already under way, or as delay outputs that change between boundaries. Random segments run every divide value against every phase and every gating combination. Directed cases cover a mid-period change of the divide value, and the stop, activity and idle gating paths.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int unsigned DIV_W = 6;
  parameter int unsigned PH_W  = 2;
  parameter int unsigned DLY_W = 4;
  localparam int unsigned N_TAPS = 3;

  // Position within the period at which a quarter-phase tap fires
  function automatic logic [DIV_W-1:0] quarter_tap(input logic [DIV_W-1:0] div,
                                                   input logic [PH_W-1:0] ph);
    int unsigned prod;
    if (div == '0) return '0;
    prod = (32'(ph) * 32'(div)) + 32'd2;
    prod = prod / 32'd4;
    return DIV_W'(prod % 32'(div));
  endfunction

  // Gate decision taken at a period boundary
  function automatic logic gate_open(input logic [DIV_W-1:0] div, input logic stop,
                                     input logic keep_on, input logic reg_acc,
                                     input logic desc_act, input logic auto_en,
                                     input logic idle, input logic pend);
    logic demand, idle_off;
    demand   = keep_on | reg_acc | desc_act;
    idle_off = auto_en & idle & ~pend;
    return (div != '0) & ~stop & demand & ~idle_off;
  endfunction
endpackage

// File: rtl/clkdiv_period_ctr.sv
module clkdiv_period_ctr
  import clkdiv_pkg::*;
#(
  parameter int unsigned W = DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_q,
  output logic [W-1:0] cnt,
  output logic         boundary
);
  localparam logic [W-1:0] ONE = W'(1);

  assign boundary = (div_q == '0) || (cnt == div_q - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (boundary) cnt <= '0;
    else               cnt <= cnt + ONE;
  end

  // R3: the counter never leaves the captured period
  a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) |-> (cnt < div_q));
endmodule

// File: rtl/clkdiv_phase_tap.sv
module clkdiv_phase_tap
  import clkdiv_pkg::*;
#(
  parameter int unsigned W = DIV_W
) (
  input  logic [W-1:0]    cnt,
  input  logic [W-1:0]    div_q,
  input  logic [PH_W-1:0] ph_q,
  input  logic            run,
  output logic            ce
);
  logic [W-1:0] tap_pos;
  assign tap_pos = quarter_tap(div_q, ph_q);
  assign ce      = run && (div_q != '0) && (cnt == tap_pos);
endmodule

// File: rtl/clkdiv_phased_gate.sv
module clkdiv_phased_gate
  import clkdiv_pkg::*;
#(
  parameter int unsigned W  = DIV_W,
  parameter int unsigned DW = DLY_W
) (
  input  logic          clk_src,
  input  logic          rst_n,
  input  logic [W-1:0]  div_i,
  input  logic [1:0]    core_ph_i,
  input  logic [1:0]    tx_ph_i,
  input  logic [1:0]    rx_ph_i,
  input  logic [DW-1:0] tx_dly_i,
  input  logic [DW-1:0] rx_dly_i,
  input  logic          always_on_i,
  input  logic          auto_gate_i,
  input  logic          stop_i,
  input  logic          reg_access_i,
  input  logic          desc_active_i,
  input  logic          bus_idle_i,
  input  logic          desc_pending_i,
  output logic          core_ce_o,
  output logic          tx_ce_o,
  output logic          rx_ce_o,
  output logic [DW-1:0] tx_dly_o,
  output logic [DW-1:0] rx_dly_o,
  output logic          clk_running_o
);
  logic [W-1:0]    div_q;
  logic [W-1:0]    cnt;
  logic            boundary;
  logic            run_q;
  logic            want_run;
  logic [1:0]      ph_in  [N_TAPS];
  logic [1:0]      ph_q   [N_TAPS];
  logic [N_TAPS-1:0] ce_vec;

  assign ph_in[0] = core_ph_i;
  assign ph_in[1] = tx_ph_i;
  assign ph_in[2] = rx_ph_i;

  assign want_run = gate_open(div_i, stop_i, always_on_i, reg_access_i,
                              desc_active_i, auto_gate_i, bus_idle_i, desc_pending_i);

  clkdiv_period_ctr #(.W(W)) u_ctr (
    .clk(clk_src), .rst_n(rst_n), .div_q(div_q), .cnt(cnt), .boundary(boundary));

  // Settings and gate are captured together, only at a boundary
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      run_q    <= 1'b0;
      tx_dly_o <= '0;
      rx_dly_o <= '0;
    end else if (boundary) begin
      div_q    <= div_i;
      run_q    <= want_run;
      tx_dly_o <= tx_dly_i;
      rx_dly_o <= rx_dly_i;
    end
  end

  generate
    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
      always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n)        ph_q[t] <= '0;
        else if (boundary) ph_q[t] <= ph_in[t];
      end
      clkdiv_phase_tap #(.W(W)) u_tap (
        .cnt(cnt), .div_q(div_q), .ph_q(ph_q[t]), .run(run_q), .ce(ce_vec[t]));
    end
  endgenerate

  assign core_ce_o     = ce_vec[0];
  assign tx_ce_o       = ce_vec[1];
  assign rx_ce_o       = ce_vec[2];
  assign clk_running_o = run_q;

  // R1: divide value 0 silences every enable
  a_r1_off_silent: assert property (@(posedge clk_src) disable iff (!rst_n)
    (div_q == '0) |-> (ce_vec == '0 && !clk_running_o));
  // R2: bypass keeps every enable high
  a_r2_bypass_all: assert property (@(posedge clk_src) disable iff (!rst_n)
    (run_q && div_q == W'(1)) |-> (ce_vec == '1));
  // R3: no two core enables back to back inside one period
  a_r3_single_core: assert property (@(posedge clk_src) disable iff (!rst_n)
    (core_ce_o && div_q > W'(1) && !boundary) |=> !core_ce_o);
  // R5: settings hold between boundaries
  a_r5_hold_div: assert property (@(posedge clk_src) disable iff (!rst_n)
    !boundary |=> $stable(div_q));
  // R6: stop gates the next period
  a_r6_stop_gates: assert property (@(posedge clk_src) disable iff (!rst_n)
    (boundary && stop_i) |=> !clk_running_o);
  // R9: delay outputs move only at a boundary
  a_r9_dly_hold: assert property (@(posedge clk_src) disable iff (!rst_n)
    !boundary |=> ($stable(tx_dly_o) && $stable(rx_dly_o)));
endmodule

// File: tb/clkdiv_phased_gate_tb.sv
module clkdiv_phased_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] div_i = '0;
  logic [1:0] cph = '0, tph = '0, rph = '0;
  logic [3:0] tdly = '0, rdly = '0;
  logic aon = 1'b0, agate = 1'b0, stop = 1'b0, racc = 1'b0, dact = 1'b0;
  logic idle = 1'b0, pend = 1'b0;
  logic core_ce, tx_ce, rx_ce, running;
  logic [3:0] tdly_o, rdly_o;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  clkdiv_phased_gate u_dut (
    .clk_src(clk), .rst_n(rst_n), .div_i(div_i), .core_ph_i(cph), .tx_ph_i(tph),
    .rx_ph_i(rph), .tx_dly_i(tdly), .rx_dly_i(rdly), .always_on_i(aon),
    .auto_gate_i(agate), .stop_i(stop), .reg_access_i(racc), .desc_active_i(dact),
    .bus_idle_i(idle), .desc_pending_i(pend), .core_ce_o(core_ce), .tx_ce_o(tx_ce),
    .rx_ce_o(rx_ce), .tx_dly_o(tdly_o), .rx_dly_o(rdly_o), .clk_running_o(running));

  // Bench-side restatement of the requirements
  int m_div = 0, m_pos = 0, m_run = 0, m_tdly = 0, m_rdly = 0;
  int m_ph[3] = '{0, 0, 0};

  function automatic int fire_at(int n, int p);
    if (n == 0) return -1;
    return ((p * n + 2) / 4) % n;
  endfunction

  function automatic int may_run(int n);
    if (n == 0 || stop) return 0;
    if (!(aon || racc || dact)) return 0;
    if (agate && idle && !pend) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_pos = 0; m_run = 0; m_tdly = 0; m_rdly = 0;
      m_ph = '{0, 0, 0};
    end else if (m_div == 0 || m_pos == m_div - 1) begin
      m_run = may_run(int'(div_i));
      m_div = int'(div_i);
      m_ph = '{int'(cph), int'(tph), int'(rph)};
      m_tdly = int'(tdly); m_rdly = int'(rdly);
      m_pos = 0;
    end else begin
      m_pos = m_pos + 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int exp_ce(int t);
    return (m_run != 0 && m_pos == fire_at(m_div, m_ph[t])) ? 1 : 0;
  endfunction

  // Advance one cycle; compare at the falling edge
  task automatic step();
    string ct, pt;
    @(negedge clk);
    cyc++;
    ct = (m_div == 0) ? "R1" : (m_div == 1) ? "R2" : "R3";
    pt = (m_div == 0) ? "R1" : (m_div == 1) ? "R2" : "R4";
    check({ct, " core_ce"}, int'(core_ce), exp_ce(0));
    check({pt, " tx_ce"}, int'(tx_ce), exp_ce(1));
    check({pt, " rx_ce"}, int'(rx_ce), exp_ce(2));
    check("R7 clk_running", int'(running), m_run);
    check("R9 tx_dly", int'(tdly_o), m_tdly);
    check("R9 rx_dly", int'(rdly_o), m_rdly);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Cycles until the next core enable
  task automatic gap_to_core(output int g);
    g = 0;
    do begin step(); g++; end while (!core_ce && g < 200);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    int g;
    void'($urandom(32'd20240611));
    #1;
    check("R10 core_ce", int'(core_ce), 0);
    check("R10 clk_running", int'(running), 0);
    check("R10 tx_dly", int'(tdly_o), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 rx_ce", int'(rx_ce), 0);

    // R2 bypass
    aon = 1'b1; div_i = 6'd1; tph = 2'd3;
    steps(10);
    check("R2 tx_ce bypass", int'(tx_ce), 1);

    // R5: change divide mid-period, old length must finish
    div_i = 6'd8; cph = 2'd0;
    gap_to_core(g); gap_to_core(g);
    steps(2);
    div_i = 6'd3;
    gap_to_core(g);
    check("R5 old period kept", g, 6);
    gap_to_core(g);
    check("R5 new period", g, 3);

    // R6 stop overrides activity
    div_i = 6'd4; racc = 1'b1; steps(6);
    stop = 1'b1; steps(6);
    check("R6 stopped", int'(running), 0);
    stop = 1'b0; racc = 1'b0; steps(6);

    // R7 activity gating
    aon = 1'b0; steps(6);
    check("R7 idle off", int'(running), 0);
    dact = 1'b1; steps(6);
    check("R7 desc on", int'(running), 1);

    // R8 automatic idle gating
    agate = 1'b1; idle = 1'b1; pend = 1'b0; steps(6);
    check("R8 idle gated", int'(running), 0);
    pend = 1'b1; steps(6);
    check("R8 pending runs", int'(running), 1);

    // R1 off
    div_i = 6'd0; steps(70);
    check("R1 off", int'(running), 0);

    // Random segments
    for (int s = 0; s < 400; s++) begin
      int r;
      r = int'($urandom_range(0, 9));
      div_i = (r == 0) ? 6'd0 : (r == 1) ? 6'd1 : (r < 5) ? 6'($urandom_range(2, 5))
                                         : 6'($urandom_range(2, 63));
      cph = 2'($urandom); tph = 2'($urandom); rph = 2'($urandom);
      tdly = 4'($urandom); rdly = 4'($urandom);
      aon = ($urandom_range(0, 3) != 0); agate = 1'($urandom);
      stop = ($urandom_range(0, 7) == 0); racc = 1'($urandom); dact = 1'($urandom);
      idle = 1'($urandom); pend = 1'($urandom);
      steps(int'($urandom_range(20, 200)));
    end
    finish_run();
  end
endmodule